// File: doc/BRIEF.md
# SIMD Processing Element

This block is one lane of a lock-step SIMD array. A controller sends the same decoded instruction to every lane. Each lane holds a 32-bit accumulator, an enable bit and a small private word memory. An arithmetic or logic instruction combines the accumulator with an operand and writes the result back to the accumulator. The operand comes from one of three places:

- a routed source: one of the neighbour values, or the lane's own fixed position number;
- the instruction's immediate field;
- the private memory, at the address the instruction carries.

A store instruction copies the accumulator into the private memory. Six compare instructions test the accumulator against the immediate and write the result into the lane's own enable bit. This lets a program narrow or rebuild the set of active lanes without going through the controller.

The controller can also load the enable bit directly. The array connects each lane's accumulator output to its neighbours, and the update strobe tells them when a new value is present. Edge wrap and which lane counts as which neighbour are decided by the array, not by this block.

Control is a two-state machine. In `ST_IDLE`, `ready` is high. When `instr_valid` is seen, the lane latches the opcode, address and selected operand, and moves to `ST_EXEC` (transition "accept"). In `ST_EXEC`, `ready` is low. The instruction completes at the next clock edge, and the machine returns to `ST_IDLE` (transition "retire"). Without `instr_valid`, `ST_IDLE` stays where it is.

Top module: `simd_pe`

## Requirements
- R1: After reset, the outputs are: `acc_out` = 0, `en_out` = 1, `acc_upd` = 0, `div_err` = 0 and `ready` = 1. Every memory word reads 0.
- R2: Accept and retire timing:
  - An instruction is accepted on a rising edge where `instr_valid` and `ready` are both high.
  - `ready` is low for exactly the one following cycle.
  - The instruction's effects appear at the next rising edge.
- R3: The operand is chosen by `instr_form`:
  - Form 0 is a routed source, chosen by `instr_src`:
    - a value below NUM_NBR picks the neighbour word `nbr_in[src*W +: W]`;
    - the value NUM_NBR gives PE_INDEX;
    - any larger value gives 0.
  - Form 1 is `instr_imm`.
  - Form 2 is the memory word at `instr_addr`.
  - Form 3 gives 0.
  - The operand is sampled at the accept edge.
- R4: Arithmetic opcodes, with A the accumulator and B the operand:
  - 0: load B;
  - 1: A+B;
  - 2: A-B;
  - 3: B-A;
  - 4: A*B, keeping the low 32 bits;
  - 5: A/B, signed and truncating toward zero;
  - 6: B/A, signed and truncating toward zero.
  - Dividing by -1 gives the two's-complement negation of the dividend.
- R5: Logic and shift opcodes:
  - 7: AND;
  - 8: OR;
  - 9: XOR;
  - 10: shift left logical;
  - 11: shift right logical;
  - 12: shift right arithmetic.
  - The shift distance is the low 5 bits of B.
- R6: Opcode 13 writes the accumulator into the memory word at `instr_addr`. The accumulator is unchanged and `acc_upd` stays low.
- R7: While `en_out` is 0, opcodes 0 to 13 change neither the accumulator, the memory nor `div_err`, and `acc_upd` stays low.
- R8: Compare opcodes test the accumulator against `instr_imm` as signed 32-bit numbers:
  - 16: =;
  - 17: !=;
  - 18: >;
  - 19: <;
  - 20: >=;
  - 21: <=.
  - Each writes its result into `en_out`, whatever the current enable value.
  - A compare leaves the accumulator unchanged.
- R9: `acc_upd` is high for exactly one cycle, starting at the retire edge of each instruction that writes the accumulator. `acc_out` never changes at any other time.
- R10: When an enabled divide (opcode 5 or 6) has a divisor of 0:
  - the accumulator keeps its value;
  - `acc_upd` stays low;
  - `div_err` is set and stays set until reset.
- R11: While `mask_wr` is high at a rising edge, `en_out` takes `mask_in`. If a compare retires on the same edge, the compare result wins.
- R12: Opcodes 14, 15 and 22 to 31 leave the accumulator, `en_out`, the memory and `div_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Broadcast instruction present |
| instr_op | input | 5 | Opcode |
| instr_form | input | 2 | Operand form |
| instr_src | input | SRC_W | Routed source select |
| instr_imm | input | W | Immediate field |
| instr_addr | input | ADDR_W | Local memory address |
| nbr_in | input | NUM_NBR*W | Neighbour accumulator values, packed |
| mask_wr | input | 1 | Load enable bit from mask_in |
| mask_in | input | 1 | Enable value to load |
| ready | output | 1 | High in ST_IDLE |
| en_out | output | 1 | Enable bit |
| acc_out | output | W | Accumulator |
| acc_upd | output | 1 | Accumulator updated strobe |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
If an instruction is accepted at rising edge k, then `acc_out`, `acc_upd`, `en_out`, `div_err` and the memory all change at edge k+1. The bench drives the instruction at a falling edge and checks `ready` = 0 one time unit after edge k. It samples every result one time unit after edge k+1, and refreshes its model only after that sample.

For mask loads and the compare-versus-mask conflict, the bench samples one time unit after the edge where `mask_wr` was high. Memory contents are read back through form-2 loads, so every store and every suppressed store is observed at the ports.

// File: rtl/simd_pe_pkg.sv
package simd_pe_pkg;

    typedef enum logic [4:0] {
        OP_LOAD  = 5'd0,
        OP_ADD   = 5'd1,
        OP_SUB   = 5'd2,
        OP_RSUB  = 5'd3,
        OP_MUL   = 5'd4,
        OP_DIV   = 5'd5,
        OP_RDIV  = 5'd6,
        OP_AND   = 5'd7,
        OP_OR    = 5'd8,
        OP_XOR   = 5'd9,
        OP_SLL   = 5'd10,
        OP_SRL   = 5'd11,
        OP_SRA   = 5'd12,
        OP_STORE = 5'd13,
        OP_CEQ   = 5'd16,
        OP_CNE   = 5'd17,
        OP_CGT   = 5'd18,
        OP_CLT   = 5'd19,
        OP_CGE   = 5'd20,
        OP_CLE   = 5'd21
    } pe_op_e;

    typedef enum logic [1:0] {
        FORM_ROUTE = 2'd0,
        FORM_IMM   = 2'd1,
        FORM_MEM   = 2'd2,
        FORM_NONE  = 2'd3
    } pe_form_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } pe_state_e;

endpackage

// File: rtl/pe_local_mem.sv
module pe_local_mem #(
    parameter int W      = 32,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      rdata
);
    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/pe_operand_sel.sv
module pe_operand_sel
    import simd_pe_pkg::*;
#(
    parameter int W        = 32,
    parameter int NUM_NBR  = 4,
    parameter int PE_INDEX = 0,
    parameter int SRC_W    = $clog2(NUM_NBR + 1)
) (
    input  logic [1:0]         form,
    input  logic [SRC_W-1:0]   src,
    input  logic [W-1:0]       imm,
    input  logic [W-1:0]       mem_word,
    input  logic [NUM_NBR*W-1:0] nbr_in,
    output logic [W-1:0]       opnd
);
    logic [W-1:0] nbr_arr [NUM_NBR];
    logic [W-1:0] routed;

    for (genvar g = 0; g < NUM_NBR; g++) begin : g_unpack
        assign nbr_arr[g] = nbr_in[g*W +: W];
    end

    always_comb begin
        routed = '0;
        for (int i = 0; i < NUM_NBR; i++) begin
            if (src == SRC_W'(i)) begin
                routed = nbr_arr[i];
            end
        end
        if (src == SRC_W'(NUM_NBR)) begin
            routed = W'(PE_INDEX);
        end
    end

    always_comb begin
        unique case (pe_form_e'(form))
            FORM_ROUTE: opnd = routed;
            FORM_IMM:   opnd = imm;
            FORM_MEM:   opnd = mem_word;
            FORM_NONE:  opnd = '0;
        endcase
    end
endmodule

// File: rtl/pe_alu.sv
module pe_alu
    import simd_pe_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [4:0]   op,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] result,
    output logic         writes_acc,
    output logic         div_zero,
    output logic         is_store,
    output logic         is_cmp,
    output logic         cmp_true
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] shamt;
    logic signed [W-1:0] sa;
    logic signed [W-1:0] sb;

    assign shamt = opnd[SH_W-1:0];
    assign sa    = $signed(acc);
    assign sb    = $signed(opnd);

    function automatic logic [W-1:0] sdiv(input logic [W-1:0] num, input logic [W-1:0] den);
        if (den == '1) begin
            return '0 - num;
        end else if (den == '0) begin
            return num;
        end else begin
            return W'($signed(num) / $signed(den));
        end
    endfunction

    always_comb begin
        result     = acc;
        writes_acc = 1'b1;
        div_zero   = 1'b0;
        is_store   = 1'b0;
        is_cmp     = 1'b0;
        cmp_true   = 1'b0;
        case (pe_op_e'(op))
            OP_LOAD: result = opnd;
            OP_ADD:  result = acc + opnd;
            OP_SUB:  result = acc - opnd;
            OP_RSUB: result = opnd - acc;
            OP_MUL:  result = acc * opnd;
            OP_DIV: begin
                result   = sdiv(acc, opnd);
                div_zero = (opnd == '0);
            end
            OP_RDIV: begin
                result   = sdiv(opnd, acc);
                div_zero = (acc == '0);
            end
            OP_AND:  result = acc & opnd;
            OP_OR:   result = acc | opnd;
            OP_XOR:  result = acc ^ opnd;
            OP_SLL:  result = acc << shamt;
            OP_SRL:  result = acc >> shamt;
            OP_SRA:  result = W'(sa >>> shamt);
            OP_STORE: begin
                writes_acc = 1'b0;
                is_store   = 1'b1;
            end
            OP_CEQ: begin writes_acc = 1'b0; is_cmp = 1'b1; cmp_true = (sa == sb); end
            OP_CNE: begin writes_acc = 1'b0; is_cmp = 1'b1; cmp_true = (sa != sb); end
            OP_CGT: begin writes_acc = 1'b0; is_cmp = 1'b1; cmp_true = (sa >  sb); end
            OP_CLT: begin writes_acc = 1'b0; is_cmp = 1'b1; cmp_true = (sa <  sb); end
            OP_CGE: begin writes_acc = 1'b0; is_cmp = 1'b1; cmp_true = (sa >= sb); end
            OP_CLE: begin writes_acc = 1'b0; is_cmp = 1'b1; cmp_true = (sa <= sb); end
            default: writes_acc = 1'b0;
        endcase
    end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
    import simd_pe_pkg::*;
#(
    parameter int W        = 32,
    parameter int NUM_NBR  = 4,
    parameter int DEPTH    = 16,
    parameter int PE_INDEX = 5,
    localparam int SRC_W   = $clog2(NUM_NBR + 1),
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [4:0]           instr_op,
    input  logic [1:0]           instr_form,
    input  logic [SRC_W-1:0]     instr_src,
    input  logic [W-1:0]         instr_imm,
    input  logic [ADDR_W-1:0]    instr_addr,
    input  logic [NUM_NBR*W-1:0] nbr_in,
    input  logic                 mask_wr,
    input  logic                 mask_in,
    output logic                 ready,
    output logic                 en_out,
    output logic [W-1:0]         acc_out,
    output logic                 acc_upd,
    output logic                 div_err
);
    pe_state_e         state_q, state_d;
    logic [4:0]        op_q;
    logic [W-1:0]      opnd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [W-1:0]      acc_q;
    logic              en_q, upd_q, err_q;

    logic [W-1:0] mem_rdata, sel_opnd, alu_res;
    logic         alu_wr, alu_dz, alu_st, alu_cmp, alu_ct;
    logic         accept, op_is_cmp, exec, mem_we;

    assign accept    = (state_q == ST_IDLE) && instr_valid;
    assign op_is_cmp = (instr_op >= 5'd16) && (instr_op <= 5'd21);
    assign exec      = (state_q == ST_EXEC);
    assign mem_we    = exec && alu_st && en_q;

    pe_local_mem #(.W(W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr_q),
        .wdata (acc_q),
        .raddr (instr_addr),
        .rdata (mem_rdata)
    );

    pe_operand_sel #(.W(W), .NUM_NBR(NUM_NBR), .PE_INDEX(PE_INDEX), .SRC_W(SRC_W)) u_sel (
        .form     (instr_form),
        .src      (instr_src),
        .imm      (instr_imm),
        .mem_word (mem_rdata),
        .nbr_in   (nbr_in),
        .opnd     (sel_opnd)
    );

    pe_alu #(.W(W)) u_alu (
        .op         (op_q),
        .acc        (acc_q),
        .opnd       (opnd_q),
        .result     (alu_res),
        .writes_acc (alu_wr),
        .div_zero   (alu_dz),
        .is_store   (alu_st),
        .is_cmp     (alu_cmp),
        .cmp_true   (alu_ct)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: accept and retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (instr_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
        endcase
    end

    // instruction latch at accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            opnd_q <= '0;
            addr_q <= '0;
        end else if (accept) begin
            op_q   <= instr_op;
            opnd_q <= op_is_cmp ? instr_imm : sel_opnd;
            addr_q <= instr_addr;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            en_q  <= 1'b1;
            upd_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (mask_wr) en_q <= mask_in;
                end
                ST_EXEC: begin
                    if (alu_wr && en_q && !alu_dz) begin
                        acc_q <= alu_res;
                        upd_q <= 1'b1;
                    end
                    if (alu_wr && en_q && alu_dz) begin
                        err_q <= 1'b1;
                    end
                    if (alu_cmp) begin
                        en_q <= alu_ct;
                    end else if (mask_wr) begin
                        en_q <= mask_in;
                    end
                end
            endcase
        end
    end

    assign ready   = (state_q == ST_IDLE);
    assign en_out  = en_q;
    assign acc_out = acc_q;
    assign acc_upd = upd_q;
    assign div_err = err_q;
endmodule

// File: rtl/simd_pe_checker.sv
module simd_pe_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         instr_valid,
    input logic         ready,
    input logic         en_out,
    input logic [W-1:0] acc_out,
    input logic         acc_upd,
    input logic         div_err
);
    assert_accept_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && ready) |=> !ready);

    assert_single_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);

    assert_gated_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_upd |-> $past(en_out));

    assert_acc_only_with_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_out) |-> acc_upd);

    assert_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_upd |=> !acc_upd);

    assert_strobe_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_upd |-> $past(instr_valid && ready, 2));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |=> div_err);
endmodule

bind simd_pe simd_pe_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .ready       (ready),
    .en_out      (en_out),
    .acc_out     (acc_out),
    .acc_upd     (acc_upd),
    .div_err     (div_err)
);

// File: tb/simd_pe_bench.sv
`timescale 1ns/1ps
module simd_pe_bench;
    localparam int W = 32;
    localparam int NN = 4;
    localparam int PEI = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [4:0]  instr_op = '0;
    logic [1:0]  instr_form = '0;
    logic [2:0]  instr_src = '0;
    logic [31:0] instr_imm = '0;
    logic [3:0]  instr_addr = '0;
    logic [NN*W-1:0] nbr_in = '0;
    logic        mask_wr = 1'b0;
    logic        mask_in = 1'b0;
    logic        ready, en_out, acc_upd, div_err;
    logic [31:0] acc_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_acc = '0;
    logic        m_en = 1'b1;
    logic        m_err = 1'b0;
    logic [31:0] m_mem [16];

    always #2.5 clk = ~clk;

    simd_pe #(.W(W), .NUM_NBR(NN), .DEPTH(16), .PE_INDEX(PEI)) u_simd_pe (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_form(instr_form), .instr_src(instr_src), .instr_imm(instr_imm),
        .instr_addr(instr_addr), .nbr_in(nbr_in), .mask_wr(mask_wr), .mask_in(mask_in),
        .ready(ready), .en_out(en_out), .acc_out(acc_out), .acc_upd(acc_upd), .div_err(div_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_div(input logic [31:0] n, input logic [31:0] d);
        if (d == 32'hffff_ffff) return 32'd0 - n;
        return 32'($signed(n) / $signed(d));
    endfunction

    function automatic logic [31:0] ref_op(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            0: return b;
            1: return a + b;
            2: return a - b;
            3: return b - a;
            4: return a * b;
            5: return ref_div(a, b);
            6: return ref_div(b, a);
            7: return a & b;
            8: return a | b;
            9: return a ^ b;
            10: return a << b[4:0];
            11: return a >> b[4:0];
            default: return 32'($signed(a) >>> b[4:0]);
        endcase
    endfunction

    function automatic logic ref_cmp(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            16: return $signed(a) == $signed(b);
            17: return $signed(a) != $signed(b);
            18: return $signed(a) >  $signed(b);
            19: return $signed(a) <  $signed(b);
            20: return $signed(a) >= $signed(b);
            default: return $signed(a) <= $signed(b);
        endcase
    endfunction

    task automatic issue(input int op, input int form, input int src, input logic [31:0] imm,
                         input int addr, input string tag);
        logic [31:0] b, e_acc;
        logic e_upd, dz;
        if (form == 0) b = (src < NN) ? nbr_in[src*W +: W] : (src == NN) ? 32'(PEI) : 32'd0;
        else if (form == 1) b = imm;
        else if (form == 2) b = m_mem[addr];
        else b = 32'd0;
        if (op >= 16 && op <= 21) b = imm;
        e_acc = m_acc;
        e_upd = 1'b0;
        dz = (op == 5 && b == 0) || (op == 6 && m_acc == 0);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_op = 5'(op);
        instr_form = 2'(form);
        instr_src = 3'(src);
        instr_imm = imm;
        instr_addr = 4'(addr);
        @(posedge clk); #1;
        instr_valid = 1'b0;
        check("R2 ready low in exec", {31'd0, ready}, 32'd0);
        @(posedge clk); #1;
        if (op <= 12 && m_en) begin
            if (dz) m_err = 1'b1;
            else begin e_acc = ref_op(op, m_acc, b); e_upd = 1'b1; end
        end
        if (op == 13 && m_en) m_mem[addr] = m_acc;
        if (op >= 16 && op <= 21) m_en = ref_cmp(op, m_acc, b);
        m_acc = e_acc;
        check(tag, acc_out, e_acc);
        check("R9 strobe", {31'd0, acc_upd}, {31'd0, e_upd});
        check({tag, " enable"}, {31'd0, en_out}, {31'd0, m_en});
        check("R10 err flag", {31'd0, div_err}, {31'd0, m_err});
        check("R2 ready back", {31'd0, ready}, 32'd1);
    endtask

    task automatic set_mask(input logic v);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_in = v;
        @(posedge clk); #1;
        mask_wr = 1'b0;
        m_en = v;
        check("R11 mask load", {31'd0, en_out}, {31'd0, v});
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] av [4];
        logic [31:0] bv [6];
        av = '{32'd5, 32'hffff_fff7, 32'd100, 32'h8000_0000};
        bv = '{32'd0, 32'd1, 32'hffff_ffff, 32'd7, 32'hffff_fff3, 32'h7fff_ffff};
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 acc reset", acc_out, 32'd0);
        check("R1 en reset", {31'd0, en_out}, 32'd1);
        check("R1 upd reset", {31'd0, acc_upd}, 32'd0);
        check("R1 err reset", {31'd0, div_err}, 32'd0);
        rst_n = 1'b1;
        check("R1 ready reset", {31'd0, ready}, 32'd1);
        issue(0, 2, 0, 0, 9, "R1 memory reads zero");

        // R10: divide by zero, then sticky
        issue(0, 1, 0, 32'd42, 0, "R4 load");
        issue(5, 1, 0, 32'd0, 0, "R10 div by zero keeps acc");
        issue(1, 1, 0, 32'd3, 0, "R10 sticky after add");
        issue(0, 1, 0, 32'd0, 0, "R4 load zero");
        issue(6, 1, 0, 32'd9, 0, "R10 reverse div by zero");

        // R3 R4 R5: sweep of ops, forms, values
        for (int op = 0; op < 13; op++) begin
            for (int f = 0; f < 3; f++) begin
                for (int ai = 0; ai < 4; ai++) begin
                    for (int bi = 0; bi < 6; bi++) begin
                        int slot;
                        int src;
                        slot = (ai * 6 + bi) % 16;
                        src = bi % NN;
                        if (f == 0) nbr_in[src*W +: W] = bv[bi];
                        if (f == 2) begin
                            issue(0, 1, 0, bv[bi], 0, "R4 load");
                            issue(13, 0, 0, 0, slot, "R6 store");
                        end
                        issue(0, 1, 0, av[ai], 0, "R4 load");
                        issue(op, f, src, bv[bi], slot, (op < 7) ? "R4 arith R3" : "R5 logic R3");
                    end
                end
            end
        end

        // R3: own index, out-of-range source, empty form
        issue(0, 0, NN, 0, 0, "R3 own index");
        issue(1, 0, NN, 0, 0, "R3 own index add");
        issue(0, 0, 6, 0, 0, "R3 invalid source is zero");
        issue(0, 1, 0, 32'd77, 0, "R4 load");
        issue(0, 3, 0, 32'd99, 0, "R3 form 3 is zero");

        // R6: store then read back
        issue(0, 1, 0, 32'hdead_beef, 0, "R4 load");
        issue(13, 0, 0, 0, 15, "R6 store keeps acc");
        issue(0, 1, 0, 32'd1, 0, "R4 load");
        issue(0, 2, 0, 0, 15, "R6 readback");

        // R7: disabled lane
        issue(0, 1, 0, 32'd11, 0, "R4 load");
        set_mask(1'b0);
        issue(0, 1, 0, 32'd500, 0, "R7 load gated");
        issue(2, 1, 0, 32'd3, 0, "R7 sub gated");
        issue(5, 1, 0, 32'd0, 0, "R7 div gated");
        issue(13, 0, 0, 0, 14, "R7 store gated");
        set_mask(1'b1);
        issue(0, 2, 0, 0, 14, "R7 memory untouched");

        // R8: compares from both enable states
        for (int op = 16; op <= 21; op++) begin
            for (int ai = 0; ai < 4; ai++) begin
                for (int bi = 0; bi < 6; bi++) begin
                    set_mask(1'((op + bi) % 2));
                    m_en = 1'((op + bi) % 2);
                    if (m_en == 1'b0) set_mask(1'b1);
                    issue(0, 1, 0, av[ai], 0, "R4 load");
                    set_mask(1'((op + ai) % 2));
                    issue(op, 0, 0, (bi == 5) ? av[ai] : bv[bi], 0, "R8 compare");
                end
            end
        end

        // R11: compare and mask load on same edge
        set_mask(1'b1);
        issue(0, 1, 0, 32'd4, 0, "R4 load");
        for (int k = 0; k < 2; k++) begin
            logic want;
            want = (k == 0);
            @(negedge clk);
            instr_valid = 1'b1;
            instr_op = 5'd16;
            instr_imm = want ? 32'd4 : 32'd5;
            @(posedge clk); #1;
            instr_valid = 1'b0;
            mask_wr = 1'b1;
            mask_in = ~want;
            @(posedge clk); #1;
            mask_wr = 1'b0;
            m_en = want;
            check("R11 compare wins", {31'd0, en_out}, {31'd0, want});
        end
        set_mask(1'b1);

        // R12: undefined opcodes
        issue(0, 1, 0, 32'd123, 0, "R4 load");
        issue(14, 1, 0, 32'd9, 3, "R12 op 14 no effect");
        issue(15, 1, 0, 32'd9, 3, "R12 op 15 no effect");
        issue(22, 1, 0, 32'd0, 3, "R12 op 22 no effect");
        issue(31, 1, 0, 32'd0, 3, "R12 op 31 no effect");
        issue(0, 2, 0, 0, 3, "R12 memory untouched");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule